// File: doc/BRIEF.md
# Four-Channel Interrupt Reporting and Route Select Register

This block merges the interrupt requests of four downstream bus segments into a single shared, active-low request line. Each channel's request is active low. While any of them is asserted, the shared request is pulled low. The block does not remember requests. A request disappears from the shared line, and from the status the host reads, only once the source that raised it lets go.

The same 8-bit control byte does two jobs. Its low bits hold the route selection: an enable bit and a 2-bit channel index, which steer the downstream switch fabric. Its upper nibble shows which channels have a pending request. That nibble is sampled when the host reads the byte, and every channel is sampled whether or not it is selected. On an interrupt, the host reads the byte, finds the asserted channel bit, writes a new selection that routes to that channel, and services the device there.

The requests pass through a two-stage synchronizer. The shared request output is registered. Read data is registered, and it holds its value until the next read.

Top module: `chan_irq_hub`

## Requirements
- R1: After a synchronous reset, route_en_o is 0, route_idx_o is 0, irq_pull_o is 0 (line released) and rdata_o is 8'h00.
- R2: irq_pull_o is 1 exactly when at least one bit of irq_n_i was 0 three clock edges earlier: two synchronizer stages plus the output register.
- R3: A request is detected and reported on any channel, whether or not that channel is selected, and also when route_en_o is 0.
- R4: A read strobe loads the synchronized request state into rdata_o. Bit 4+i is 1 when channel i is requesting, so channel 0 maps to bit 4 and channel 3 maps to bit 7. The request state used is that of irq_n_i two edges before the strobe edge. The data is valid in the cycle after the strobe.
- R5: rdata_o changes only on a cycle that follows a read strobe. Between reads it holds its value, even while the requests change.
- R6: A write strobe loads wdata_i[2] into route_en_o and wdata_i[1:0] into route_idx_o. Both are visible in the next cycle. Without a write strobe, both hold their values.
- R7: wdata_i[7:3] are ignored on writes. A read returns bit 3 as 0, bit 2 as the route enable and bits 1:0 as the route index.
- R8: Nothing is sticky. Once all requests deassert, irq_pull_o returns to 0 and the next read reports 4'b0000 in bits 7:4.
- R9: When a read and a write fall in the same cycle, the read returns the selection held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_i | input | 4 | Active-low request per channel, asynchronous |
| wr_en_i | input | 1 | Write strobe for the control byte |
| rd_en_i | input | 1 | Read strobe for the control byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_pull_o | output | 1 | 1 = pull the shared request line low |
| route_en_o | output | 1 | Route enable; 0 disconnects all channels |
| route_idx_o | output | 2 | Selected channel index |

## Verification
The assertions check four things on every cycle:
- the three-edge relation between irq_n_i and irq_pull_o;
- the mapping of the requests into the upper read nibble, and the selection into the lower bits;
- the hold of the read data between strobes;
- the load and hold of the route selection.

Some behaviour only the bench scenarios can show:
- the reset values;
- a request on an unselected or disabled channel being reported;
- the request clearing with no sticky state once its source releases;
- the ordering when a read and a write fall in the same cycle.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int NUM_CH  = 4;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = $clog2(NUM_CH);
  localparam int EN_BIT  = IDX_W;
  localparam int PAD_W   = DATA_W - NUM_CH - IDX_W - 1;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } route_sel_t;
endpackage

// File: rtl/chan_irq_sync.sv
module chan_irq_sync #(
  parameter int       W       = 4,
  parameter int       STAGES  = 2,
  parameter logic     RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/chan_sel_reg.sv
module chan_sel_reg
  import chan_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output route_sel_t        sel_o
);
  logic unused_hi;
  assign unused_hi = ^wdata_i[DATA_W-1:EN_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o <= '0;
    end else if (wr_en_i) begin
      sel_o.en  <= wdata_i[EN_BIT];
      sel_o.idx <= wdata_i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/chan_irq_snap.sv
module chan_irq_snap
  import chan_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pend_i,
  input  route_sel_t        sel_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pull_o
);
  logic [DATA_W-1:0] snap_next;
  assign snap_next = {pend_i, {PAD_W{1'b0}}, sel_i.en, sel_i.idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      pull_o  <= 1'b0;
    end else begin
      pull_o <= |pend_i;
      if (rd_en_i) rdata_o <= snap_next;
    end
  end
endmodule

// File: rtl/chan_irq_hub.sv
module chan_irq_hub
  import chan_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] irq_n_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_pull_o,
  output logic              route_en_o,
  output logic [IDX_W-1:0]  route_idx_o
);
  logic [NUM_CH-1:0] irq_n_sync;
  logic [NUM_CH-1:0] pend;
  route_sel_t        sel;

  chan_irq_sync #(.W(NUM_CH), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk (clk), .rst (rst), .d_i (irq_n_i), .q_o (irq_n_sync)
  );

  assign pend = ~irq_n_sync;

  chan_sel_reg u_sel (
    .clk (clk), .rst (rst), .wr_en_i (wr_en_i), .wdata_i (wdata_i), .sel_o (sel)
  );

  chan_irq_snap u_snap (
    .clk (clk), .rst (rst), .pend_i (pend), .sel_i (sel), .rd_en_i (rd_en_i),
    .rdata_o (rdata_o), .pull_o (irq_pull_o)
  );

  assign route_en_o  = sel.en;
  assign route_idx_o = sel.idx;
endmodule

// File: rtl/chan_irq_hub_chk.sv
module chan_irq_hub_chk
  import chan_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] irq_n_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_pull_o,
  input logic              route_en_o,
  input logic [IDX_W-1:0]  route_idx_o
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= 2'd0;
    else if (age != 3) age <= age + 2'd1;
  end

  // R2
  pull_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 3) |-> (irq_pull_o == !(&$past(irq_n_i, 3))));

  // R4
  snap_map_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 3 && $past(rd_en_i)) |-> (rdata_o[DATA_W-1 -: NUM_CH] == ~$past(irq_n_i, 3)));

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));

  // R6
  sel_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (route_en_o == $past(wdata_i[EN_BIT]) && route_idx_o == $past(wdata_i[IDX_W-1:0])));

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> ($stable(route_en_o) && $stable(route_idx_o)));

  // R7
  snap_low_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> (rdata_o[EN_BIT:0] == {$past(route_en_o), $past(route_idx_o)}));
endmodule

bind chan_irq_hub chan_irq_hub_chk u_chk (.*);

// File: tb/chan_irq_hub_bench.sv
module chan_irq_hub_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] irq_n_i = 4'hF;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_pull_o, route_en_o;
  logic [1:0] route_idx_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chan_irq_hub u_chan_irq_hub (.*);

  // behavioural reference: history of sampled inputs
  logic [3:0] hist[$] = '{4'hF, 4'hF};
  logic       m_en = 0, m_pull = 0;
  logic [1:0] m_idx = 0;
  logic [7:0] m_rd = 0;
  logic       started = 0;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{4'hF, 4'hF};
      m_en = 0; m_idx = 0; m_rd = 0; m_pull = 0;
      started = 1;
    end else begin
      m_pull = (hist[1] != 4'hF);
      if (rd_en_i) m_rd = {~hist[1], 1'b0, m_en, m_idx};
      if (wr_en_i) begin m_en = wdata_i[2]; m_idx = wdata_i[1:0]; end
      hist.push_front(irq_n_i);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk({7'd0, irq_pull_o}, {7'd0, m_pull}, "R2 pull line");
    chk({5'd0, route_en_o, route_idx_o}, {5'd0, m_en, m_idx}, "R6 route select");
    chk(rdata_o, m_rd, "R4 read data");
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en_i = 1; wdata_i = v;
    @(negedge clk); wr_en_i = 0;
  endtask
  task automatic rd();
    @(negedge clk); rd_en_i = 1;
    @(negedge clk); rd_en_i = 0;
  endtask

  initial begin
    idle(3);
    chk({irq_pull_o, route_en_o, route_idx_o}, 4'b0000, "R1 reset outputs");
    chk(rdata_o, 8'h00, "R1 reset rdata");
    rst = 0;
    // R3: channel 3 requests while disabled and channel 0 indexed
    wr(8'h00);
    irq_n_i = 4'b0111;
    idle(4);
    chk({7'd0, irq_pull_o}, 8'd1, "R3 pull on unselected channel");
    rd(); chk(rdata_o, 8'h80, "R3 ch3 in bit7 while disabled");
    // R4: channels 0 and 2
    irq_n_i = 4'b1010;
    idle(4); rd(); chk(rdata_o, 8'h50, "R4 ch0 bit4 ch2 bit6");
    // R5: hold between reads
    irq_n_i = 4'b0000;
    idle(5); chk(rdata_o, 8'h50, "R5 rdata held");
    rd(); chk(rdata_o, 8'hF0, "R4 all channels");
    // R8: release, nothing sticky
    irq_n_i = 4'hF;
    idle(4);
    chk({7'd0, irq_pull_o}, 8'd0, "R8 pull released");
    rd(); chk(rdata_o, 8'h00, "R8 status cleared");
    // R6/R7: ignored upper bits, bit3 reads 0
    wr(8'hFF);
    chk({5'd0, route_en_o, route_idx_o}, 8'h07, "R6 select loaded");
    rd(); chk(rdata_o, 8'h07, "R7 upper write ignored bit3 zero");
    wr(8'hFA);
    rd(); chk(rdata_o, 8'h02, "R7 en cleared idx2");
    // R9: simultaneous read and write
    wr(8'h07);
    @(negedge clk); rd_en_i = 1; wr_en_i = 1; wdata_i = 8'h05;
    @(negedge clk); rd_en_i = 0; wr_en_i = 0;
    chk(rdata_o, 8'h07, "R9 read returns old select");
    rd(); chk(rdata_o, 8'h05, "R9 next read new select");
    // R2: short pulse on ch1
    irq_n_i = 4'b1101;
    @(negedge clk); irq_n_i = 4'hF;
    idle(6);
    chk({7'd0, irq_pull_o}, 8'd0, "R2 pull released after pulse");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule